// File: doc/BRIEF.md
# Root Port Link Bring-Up Sequencer

This block supervises the training of a single root port link after the PHY and clocks are ready. A start request opens an attempt. The attempt first waits for the data-link layer to report that it is up. It then waits for the active flag in the port's 32-bit link control/status word. The two waits are timed in order, and each wait has its own budget of millisecond ticks. A wait that runs out of budget ends the attempt. The port's reset is then pulsed for one tick period, and a fresh attempt begins.

Success ends the sequence with the link reported up. If a bounded number of attempts all fail, the block reports failure. The verdict holds until software or the boot sequencer issues the next start. Status inputs are examined only on tick cycles, so the timing follows the tick rate and not the fast clock.

Top module: `link_bringup_seq`

## Requirements
- R1: After reset, port_reset, done, link_up and fail are all low and the block is idle.
- R2: Once started, the block samples dl_up only on cycles where tick is high. dl_up held high on cycles without tick has no effect.
- R3: The link-active flag is bit 29 of link_status, and no other bit of that word matters. When the flag is seen on a tick during the second wait, done and link_up go high and fail stays low.
- R4: Each wait gives up on its 200th tick without the awaited indication. An indication sampled on that 200th tick still counts as seen.
- R5: If the first wait times out, the second wait is skipped. A set link-active flag while dl_up is low never yields success.
- R6: When a wait gives up, port_reset goes high on that tick. It stays high until the next tick and then falls, and the next attempt starts in the first wait.
- R7: A sequence makes at most 3 attempts. A failure in either wait leads to a retry while attempts remain. After the third failure and its reset pulse, done and fail go high and link_up stays low.
- R8: done, link_up and fail keep their values until the next start. A start while done is high clears them and begins a new sequence with a full attempt budget.
- R9: A start while an attempt or a reset pulse is in progress is ignored. In particular, it does not restart the running timeout.
- R10: The tick budget is reloaded on entry to each wait. The second wait gets its full 200 ticks regardless of how long the first wait took.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a bring-up sequence (accepted only when idle or done) |
| tick | input | 1 | One-cycle pulse per millisecond |
| dl_up | input | 1 | Data-link layer up indication |
| link_status | input | 32 | Link control/status word; bit 29 is the active flag |
| port_reset | output | 1 | Root port reset, pulsed between attempts |
| done | output | 1 | Sequence finished (either outcome) |
| link_up | output | 1 | Sequence finished with the link active |
| fail | output | 1 | Sequence finished after all attempts failed |

## Verification
The bench targets the timeout boundary on both sides of the 200th tick. A design off by one would pulse the reset one tick early, or would ignore an indication that arrives on the last tick. The bench lets the first wait use almost its whole budget before the second wait begins. A design that shares one timer across both phases would then time out almost at once in the second phase. A start is issued in the middle of a wait; a design that accepts it would push the timeout back. The bench holds the link-active flag high while dl_up stays low, and it holds dl_up high on cycles without a tick. A design that skips phase ordering or samples between ticks would report a false success. Full failure and late success are both run to catch an attempt count that is off by one.

// File: rtl/link_bringup_seq.sv
module link_bringup_seq #(
  parameter int TIMEOUT_TICKS = 200,
  parameter int MAX_ATTEMPTS  = 3,
  parameter int STAT_W        = 32,
  parameter int ACTIVE_BIT    = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              tick,
  input  logic              dl_up,
  input  logic [STAT_W-1:0] link_status,
  output logic              port_reset,
  output logic              done,
  output logic              link_up,
  output logic              fail
);
  localparam int TW = $clog2(TIMEOUT_TICKS + 1);
  localparam int AW = $clog2(MAX_ATTEMPTS + 1);
  localparam logic [STAT_W-1:0] ACT_MASK = STAT_W'(1) << ACTIVE_BIT;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT_DL, S_WAIT_LINK, S_RST, S_OK, S_FAIL
  } st_t;

  st_t           st;
  logic [TW-1:0] timer;
  logic [AW-1:0] left;

  wire expired   = (timer == TW'(1));
  wire link_seen = |(link_status & ACT_MASK);
  wire can_start = start && (st == S_IDLE || st == S_OK || st == S_FAIL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      timer <= '0;
      left  <= '0;
    end else if (can_start) begin
      st    <= S_WAIT_DL;
      timer <= TW'(TIMEOUT_TICKS);
      left  <= AW'(MAX_ATTEMPTS - 1);
    end else if (tick) begin
      unique case (st)
        S_WAIT_DL:
          if (dl_up) begin
            st    <= S_WAIT_LINK;
            timer <= TW'(TIMEOUT_TICKS);
          end else if (expired) st <= S_RST;
          else timer <= timer - TW'(1);
        S_WAIT_LINK:
          if (link_seen) st <= S_OK;
          else if (expired) st <= S_RST;
          else timer <= timer - TW'(1);
        S_RST:
          if (left == '0) st <= S_FAIL;
          else begin
            left  <= left - AW'(1);
            st    <= S_WAIT_DL;
            timer <= TW'(TIMEOUT_TICKS);
          end
        default: ;
      endcase
    end
  end

  assign port_reset = (st == S_RST);
  assign link_up    = (st == S_OK);
  assign fail       = (st == S_FAIL);
  assign done       = link_up | fail;
endmodule

// File: rtl/link_bringup_seq_chk.sv
module link_bringup_seq_chk #(
  parameter int MAX_ATTEMPTS = 3
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic tick,
  input logic port_reset,
  input logic done,
  input logic link_up,
  input logic fail
);
  localparam int CW = $clog2(MAX_ATTEMPTS + 2) + 1;
  logic [CW-1:0] pulses;
  logic          prev_rst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulses   <= '0;
      prev_rst <= 1'b0;
    end else begin
      prev_rst <= port_reset;
      if (done && start) pulses <= '0;
      else if (port_reset && !prev_rst) pulses <= pulses + CW'(1);
    end
  end

  // R6
  pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_reset && !tick |=> port_reset);
  // R6
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_reset && tick |=> !port_reset);
  // R6
  pulse_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_reset) |-> $past(tick));
  // R7
  attempt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulses <= CW'(MAX_ATTEMPTS));
  // R7
  fail_after_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> pulses == CW'(MAX_ATTEMPTS));
  // R8
  verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(link_up) && $stable(fail));
endmodule

bind link_bringup_seq link_bringup_seq_chk #(.MAX_ATTEMPTS(MAX_ATTEMPTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
  .port_reset(port_reset), .done(done), .link_up(link_up), .fail(fail)
);

// File: tb/link_bringup_seq_test.sv
module link_bringup_seq_test;
  localparam logic [31:0] ACT = 32'h2000_0000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, tick = 1'b0, dl_up = 1'b0;
  logic [31:0] lstat = '0;
  logic port_reset, done, link_up, fail;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  link_bringup_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick), .dl_up(dl_up),
    .link_status(lstat), .port_reset(port_reset), .done(done),
    .link_up(link_up), .fail(fail)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) do_tick();
  endtask

  task automatic kick();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 outputs in reset", {port_reset, done, link_up, fail}, 4'b0000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 outputs after reset", {port_reset, done, link_up, fail}, 4'b0000);
  endtask

  task automatic t_fast_link();
    kick();
    dl_up = 1'b1;
    repeat (5) @(negedge clk);
    dl_up = 1'b0;
    lstat = ACT;
    do_tick();
    check("R2 dl_up without tick ignored", {done, link_up}, 2'b00);
    lstat = '0;
    dl_up = 1'b1;
    do_tick();
    dl_up = 1'b0;
    lstat = ~ACT;
    do_tick();
    check("R3 other status bits ignored", {done, link_up, port_reset}, 3'b000);
    lstat = ACT;
    do_tick();
    lstat = '0;
    check("R3 success verdict", {done, link_up, fail}, 3'b110);
  endtask

  task automatic t_hold();
    ticks(5);
    check("R8 verdict held", {done, link_up, fail}, 3'b110);
    kick();
    check("R8 start clears verdict", {done, link_up, fail}, 3'b000);
  endtask

  task automatic t_busy_and_fail();
    ticks(150);
    kick();
    ticks(49);
    check("R4 no timeout at tick 199", port_reset, 1'b0);
    do_tick();
    check("R9 busy start did not reload timer", port_reset, 1'b1);
    repeat (4) @(negedge clk);
    check("R6 reset held between ticks", port_reset, 1'b1);
    do_tick();
    check("R6 reset released after one tick", {port_reset, done}, 2'b00);
    lstat = ACT;
    ticks(200);
    check("R5 link flag without dl_up no success", {port_reset, link_up}, 2'b10);
    do_tick();
    ticks(200);
    check("R7 third attempt timed out", {port_reset, fail}, 2'b10);
    lstat = '0;
    do_tick();
    check("R7 failure verdict", {done, link_up, fail, port_reset}, 4'b1010);
  endtask

  task automatic t_boundary();
    kick();
    check("R8 restart from failure", {done, fail}, 2'b00);
    ticks(199);
    dl_up = 1'b1;
    do_tick();
    dl_up = 1'b0;
    check("R4 dl_up on tick 200 counts", {port_reset, done}, 2'b00);
    ticks(199);
    check("R10 second wait has full budget", {port_reset, done}, 2'b00);
    lstat = ACT;
    do_tick();
    lstat = '0;
    check("R10 link seen on tick 200 of second wait", {done, link_up}, 2'b11);
  endtask

  task automatic t_retry_ok();
    kick();
    dl_up = 1'b1;
    do_tick();
    dl_up = 1'b0;
    ticks(199);
    check("R4 link wait alive at tick 199", port_reset, 1'b0);
    do_tick();
    check("R7 link phase timeout retries", port_reset, 1'b1);
    do_tick();
    dl_up = 1'b1;
    do_tick();
    dl_up = 1'b0;
    lstat = ACT;
    do_tick();
    lstat = '0;
    check("R7 success on second attempt", {done, link_up, fail}, 3'b110);
  endtask

  initial begin
    t_reset();
    t_fast_link();
    t_hold();
    t_busy_and_fail();
    t_boundary();
    t_retry_ok();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule